// File: doc/BRIEF.md
# Per-Port Credit Tracker and Burst Scheduler

This block sits on the transmit side of a multi-port packet link. The receiver sends back one two-bit flow-control code per status slot, and the slots follow a fixed calendar. The block maps each code to the port that owns the current slot. It keeps a credit count for every port, measured in 16-byte blocks, and decides which port sends its next burst.

A port is eligible when it holds credit and its transmit FIFO reports queued data. A round-robin arbiter chooses one eligible port. The block then offers the data formatter a request that carries the port number and a block count. That count is the smaller of the port's credit and its queued blocks. Once the formatter accepts the request, the block waits for a done strobe that reports how many bytes were sent. It charges the port in whole blocks, so a short end-of-packet burst still costs one block. The arbiter then moves on to the next port in turn.

A framing or parity error on the status channel clears every credit and realigns the calendar to slot 0. New status codes are ignored until one full clean calendar pass has been received.

Top module: `credit_sched`

## Requirements
- R1: After reset every credit is zero and `req_valid` is low, whatever the FIFO levels.
- R2: The calendar slot starts at 0 and advances by one on each `stat_valid`, wrapping after CAL_LEN slots. Slot k carries the status of port k mod NUM_PORTS.
- R3: Status code 2'b00 (port nearly empty) sets that port's credit to MAXB1 blocks, replacing any credit still outstanding.
- R4: Status code 2'b01 (port below its low mark) sets that port's credit to MAXB2 blocks, replacing the old value rather than adding to it.
- R5: Status codes 2'b10 (port full) and 2'b11 (unused) leave that port's credit unchanged.
- R6: A port is eligible when its credit is nonzero and its FIFO level is nonzero. While the block is idle and some port is eligible, `req_valid` is high. `req_blocks` then equals the smaller of the chosen port's credit and its FIFO level.
- R7: Arbitration is round robin. The search starts at the pointer, which is reset to 0. When a burst completes, the pointer moves to the port after the one that sent the burst, wrapping to port 0 after the last port.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. `req_valid` then stays low until `done_valid` is received.
- R9: When `done_valid` arrives, the burst port is charged ceil(`done_bytes`/16) blocks, so a 1 to 16 byte end-of-packet burst costs one block. If the charge exceeds the credit, the credit becomes zero rather than wrapping.
- R10: `stat_err` clears all credits and moves the calendar to slot 0. Status codes are then ignored until CAL_LEN consecutive clean status slots have been received, and code handling resumes with the slot after that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_valid | input | 1 | A status code is present for the current calendar slot |
| stat_code | input | 2 | Status code: 00 nearly empty, 01 low, 10 full, 11 unused |
| stat_err | input | 1 | Framing or parity error seen on the status channel |
| fifo_blocks | input | NUM_PORTS*LVL_W | Queued 16-byte blocks per port, port 0 in the least significant field |
| req_valid | output | 1 | A burst request is offered |
| req_port | output | PORT_W | Port chosen for the burst |
| req_blocks | output | CRED_W | Blocks granted for the burst |
| req_ready | input | 1 | Formatter accepts the request |
| done_valid | input | 1 | The accepted burst has completed |
| done_bytes | input | BYTE_W | Bytes actually sent in the burst |

## Verification
The status codes are first driven one slot at a time, with only the addressed port's FIFO non-empty. This separates the slot-to-port mapping, the two credit loads, replacement from accumulation, and the codes that must leave credit unchanged. In the next phase every FIFO is full and bursts are completed with byte counts of 64, 5, 33, 16 and 255. These counts show whether the pointer rotation is right, whether short bursts are rounded up to one block, and whether an oversized charge saturates at zero. An emptied FIFO then confirms that a port with credit but no queued data is skipped. An error pulse followed by a partial pass and then a full pass shows that credit is withheld for exactly one clean calendar pass.

// File: rtl/credit_sched_pkg.sv
package credit_sched_pkg;

   typedef enum logic [1:0] {
      ST_DRY  = 2'b00,
      ST_LOW  = 2'b01,
      ST_FULL = 2'b10,
      ST_RSVD = 2'b11
   } stat_code_e;

endpackage

// File: rtl/credit_cal.sv
module credit_cal #(
   parameter int CAL_LEN   = 8,
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_valid,
   input  logic              stat_err,
   output logic              apply,
   output logic [PORT_W-1:0] apply_port
);

   localparam int SLOT_W = (CAL_LEN > 1) ? $clog2(CAL_LEN) : 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CAL_LEN - 1);

   logic [PORT_W-1:0] cal_tab [CAL_LEN];
   logic [SLOT_W-1:0] slot;
   logic              blocked;

   for (genvar g = 0; g < CAL_LEN; g++) begin : g_cal
      assign cal_tab[g] = PORT_W'(g % NUM_PORTS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot    <= '0;
         blocked <= 1'b0;
      end else if (stat_err) begin
         slot    <= '0;
         blocked <= 1'b1;
      end else if (stat_valid) begin
         if (slot == LAST_SLOT) begin
            slot    <= '0;
            blocked <= 1'b0;
         end else begin
            slot <= slot + 1'b1;
         end
      end
   end

   assign apply      = stat_valid && !stat_err && !blocked;
   assign apply_port = cal_tab[slot];

endmodule

// File: rtl/credit_bank.sv
module credit_bank
   import credit_sched_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 2,
   parameter int CRED_W    = 4,
   parameter int CHG_W     = 5,
   parameter int MAXB1     = 8,
   parameter int MAXB2     = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        apply,
   input  logic [PORT_W-1:0]           apply_port,
   input  logic [1:0]                  apply_code,
   input  logic                        ded_en,
   input  logic [PORT_W-1:0]           ded_port,
   input  logic [CHG_W-1:0]            ded_amt,
   output logic [NUM_PORTS*CRED_W-1:0] credit
);

   localparam int EW = ((CRED_W > CHG_W) ? CRED_W : CHG_W) + 1;

   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
      logic [CRED_W-1:0] cnt;
      logic [EW-1:0]     cnt_e;
      logic [EW-1:0]     amt_e;
      logic [EW-1:0]     diff;
      logic              hit_apply;
      logic              hit_ded;

      assign hit_apply = apply && (apply_port == PORT_W'(g));
      assign hit_ded   = ded_en && (ded_port == PORT_W'(g));
      assign cnt_e     = EW'(cnt);
      assign amt_e     = EW'(ded_amt);
      assign diff      = cnt_e - amt_e;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            cnt <= '0;
         end else if (hit_apply && apply_code == ST_DRY) begin
            cnt <= CRED_W'(MAXB1);
         end else if (hit_apply && apply_code == ST_LOW) begin
            cnt <= CRED_W'(MAXB2);
         end else if (hit_ded) begin
            cnt <= (amt_e >= cnt_e) ? '0 : CRED_W'(diff);
         end
      end

      assign credit[g*CRED_W +: CRED_W] = cnt;
   end

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 2
) (
   input  logic [NUM_PORTS-1:0] req,
   input  logic [PORT_W-1:0]    ptr,
   output logic                 any,
   output logic [PORT_W-1:0]    sel
);

   always_comb begin
      sel = '0;
      for (int k = NUM_PORTS - 1; k >= 0; k--) begin
         int idx;
         idx = (int'(ptr) + k) % NUM_PORTS;
         if (req[idx]) sel = PORT_W'(idx);
      end
   end

   assign any = |req;

endmodule

// File: rtl/credit_sched.sv
module credit_sched #(
   parameter int NUM_PORTS = 4,
   parameter int CAL_LEN   = 8,
   parameter int MAXB1     = 8,
   parameter int MAXB2     = 4,
   parameter int LVL_W     = 5,
   parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   parameter int CRED_W    = $clog2(MAXB1 + 1),
   parameter int BYTE_W    = CRED_W + 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stat_valid,
   input  logic [1:0]                 stat_code,
   input  logic                       stat_err,
   input  logic [NUM_PORTS*LVL_W-1:0] fifo_blocks,
   output logic                       req_valid,
   output logic [PORT_W-1:0]          req_port,
   output logic [CRED_W-1:0]          req_blocks,
   input  logic                       req_ready,
   input  logic                       done_valid,
   input  logic [BYTE_W-1:0]          done_bytes
);

   localparam int CHG_W = BYTE_W - 3;
   localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);

   if (NUM_PORTS < 1 || NUM_PORTS > 16) begin : g_bad_ports
      $error("credit_sched: NUM_PORTS must be 1 to 16");
   end
   if (CAL_LEN < NUM_PORTS || CAL_LEN < 2) begin : g_bad_cal
      $error("credit_sched: CAL_LEN must cover every port");
   end
   if (MAXB2 < 1 || MAXB2 > MAXB1) begin : g_bad_burst
      $error("credit_sched: need 1 <= MAXB2 <= MAXB1");
   end
   if (BYTE_W < 5) begin : g_bad_bytes
      $error("credit_sched: BYTE_W too small");
   end

   logic                        apply;
   logic [PORT_W-1:0]           apply_port;
   logic [NUM_PORTS*CRED_W-1:0] credit;
   logic [NUM_PORTS-1:0]        elig;
   logic                        any_elig;
   logic [PORT_W-1:0]           pick;
   logic [PORT_W-1:0]           ptr;
   logic                        busy;
   logic [PORT_W-1:0]           busy_port;
   logic [BYTE_W:0]             bytes_up;
   logic [CHG_W-1:0]            charge;
   logic [CRED_W-1:0]           cred_sel;
   logic [LVL_W-1:0]            lvl_sel;

   credit_cal #(
      .CAL_LEN   (CAL_LEN),
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
   ) u_cal (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat_valid (stat_valid),
      .stat_err   (stat_err),
      .apply      (apply),
      .apply_port (apply_port)
   );

   assign bytes_up = {1'b0, done_bytes} + (BYTE_W+1)'(15);
   assign charge   = bytes_up[BYTE_W:4];

   credit_bank #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W),
      .CRED_W    (CRED_W),
      .CHG_W     (CHG_W),
      .MAXB1     (MAXB1),
      .MAXB2     (MAXB2)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (stat_err),
      .apply      (apply),
      .apply_port (apply_port),
      .apply_code (stat_code),
      .ded_en     (busy && done_valid),
      .ded_port   (busy_port),
      .ded_amt    (charge),
      .credit     (credit)
   );

   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_elig
      assign elig[g] = (credit[g*CRED_W +: CRED_W] != '0) &&
                       (fifo_blocks[g*LVL_W +: LVL_W] != '0);
   end

   rr_arbiter #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
   ) u_arb (
      .req (elig),
      .ptr (ptr),
      .any (any_elig),
      .sel (pick)
   );

   assign cred_sel = credit[pick*CRED_W +: CRED_W];
   assign lvl_sel  = fifo_blocks[pick*LVL_W +: LVL_W];

   always_comb begin
      if ((LVL_W + CRED_W)'(lvl_sel) < (LVL_W + CRED_W)'(cred_sel)) begin
         req_blocks = CRED_W'(lvl_sel);
      end else begin
         req_blocks = cred_sel;
      end
   end

   assign req_valid = !busy && any_elig;
   assign req_port  = pick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         busy_port <= '0;
         ptr       <= '0;
      end else if (!busy) begin
         if (req_valid && req_ready) begin
            busy      <= 1'b1;
            busy_port <= pick;
         end
      end else if (done_valid) begin
         busy <= 1'b0;
         ptr  <= (busy_port == LAST_PORT) ? '0 : busy_port + 1'b1;
      end
   end

endmodule

// File: rtl/credit_sched_chk.sv
module credit_sched_chk #(
   parameter int NUM_PORTS = 4,
   parameter int MAXB1     = 8,
   parameter int PORT_W    = 2,
   parameter int CRED_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stat_err,
   input logic              req_valid,
   input logic [PORT_W-1:0] req_port,
   input logic [CRED_W-1:0] req_blocks,
   input logic              req_ready
);

   // R6
   blocks_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_blocks != '0) && (int'(req_blocks) <= MAXB1));

   // R6
   port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (int'(req_port) < NUM_PORTS));

   // R8
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_valid);

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_err |=> !req_valid);

endmodule

bind credit_sched credit_sched_chk #(
   .NUM_PORTS (NUM_PORTS),
   .MAXB1     (MAXB1),
   .PORT_W    (PORT_W),
   .CRED_W    (CRED_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stat_err   (stat_err),
   .req_valid  (req_valid),
   .req_port   (req_port),
   .req_blocks (req_blocks),
   .req_ready  (req_ready)
);

// File: tb/tb_credit_sched.sv
module tb_credit_sched;

   localparam int NP  = 4;
   localparam int LW  = 5;
   localparam int PW  = 2;
   localparam int CW  = 4;
   localparam int BW  = 8;
   localparam int VW  = 2 + NP*LW + 1 + PW + CW;
   localparam int NV  = 9;
   localparam logic [NP*LW-1:0] ALL_FULL = {5'd15, 5'd15, 5'd15, 5'd15};

   // code, fifo {p3,p2,p1,p0}, expected valid, port, blocks
   localparam logic [VW-1:0] VEC [NV] = '{
      {2'b00, 5'd0, 5'd0,  5'd0,  5'd5,  1'b1, 2'd0, 4'd5},  // R2 R3 slot0 p0
      {2'b01, 5'd0, 5'd0,  5'd9,  5'd0,  1'b1, 2'd1, 4'd4},  // R4 slot1 p1
      {2'b10, 5'd0, 5'd3,  5'd0,  5'd0,  1'b0, 2'd0, 4'd0},  // R5 slot2 p2
      {2'b01, 5'd3, 5'd0,  5'd0,  5'd0,  1'b1, 2'd3, 4'd3},  // R6 slot3 p3
      {2'b01, 5'd0, 5'd0,  5'd0,  5'd15, 1'b1, 2'd0, 4'd4},  // R4 replace
      {2'b00, 5'd0, 5'd0,  5'd15, 5'd0,  1'b1, 2'd1, 4'd8},  // R3 slot5 p1
      {2'b00, 5'd0, 5'd8,  5'd0,  5'd0,  1'b1, 2'd2, 4'd8},  // R6 equal
      {2'b10, 5'd7, 5'd0,  5'd0,  5'd0,  1'b1, 2'd3, 4'd4},  // R5 keep
      {2'b11, 5'd0, 5'd0,  5'd0,  5'd2,  1'b1, 2'd0, 4'd2}   // R2 wrap, R5
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stat_valid = 1'b0;
   logic [1:0]    stat_code = 2'b00;
   logic          stat_err = 1'b0;
   logic [NP*LW-1:0] fifo_blocks = '0;
   logic          req_valid;
   logic [PW-1:0] req_port;
   logic [CW-1:0] req_blocks;
   logic          req_ready = 1'b0;
   logic          done_valid = 1'b0;
   logic [BW-1:0] done_bytes = '0;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   credit_sched dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .stat_valid  (stat_valid),
      .stat_code   (stat_code),
      .stat_err    (stat_err),
      .fifo_blocks (fifo_blocks),
      .req_valid   (req_valid),
      .req_port    (req_port),
      .req_blocks  (req_blocks),
      .req_ready   (req_ready),
      .done_valid  (done_valid),
      .done_bytes  (done_bytes)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_req(input string tag, input bit ev, input int ep, input int eb);
      chk({tag, " valid"}, int'(req_valid), int'(ev));
      if (ev) begin
         chk({tag, " port"}, int'(req_port), ep);
         chk({tag, " blocks"}, int'(req_blocks), eb);
      end
   endtask

   task automatic send_stat(input logic [1:0] c);
      @(negedge clk);
      stat_valid = 1'b1;
      stat_code  = c;
      @(negedge clk);
      stat_valid = 1'b0;
   endtask

   task automatic accept();
      @(negedge clk);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
   endtask

   task automatic finish_burst(input int nbytes);
      @(negedge clk);
      done_valid = 1'b1;
      done_bytes = BW'(nbytes);
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      fifo_blocks = ALL_FULL;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset no request", int'(req_valid), 0);

      // table walk: one status per slot, R2 R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         fifo_blocks = v[VW-3 -: NP*LW];
         send_stat(v[VW-1 -: 2]);
         chk_req($sformatf("vec%0d", i), v[PW+CW], int'(v[CW +: PW]), int'(v[CW-1:0]));
      end

      // credits now p0=4 p1=8 p2=8 p3=4, pointer at 0
      fifo_blocks = ALL_FULL;
      @(negedge clk);
      chk_req("R7 start p0", 1'b1, 0, 4);
      accept();
      chk("R8 quiet while busy", int'(req_valid), 0);
      finish_burst(64);
      chk_req("R7 next p1", 1'b1, 1, 8);
      accept();
      finish_burst(5);
      chk_req("R7 next p2", 1'b1, 2, 8);
      accept();
      finish_burst(33);
      chk_req("R7 next p3", 1'b1, 3, 4);
      accept();
      finish_burst(16);
      chk_req("R9 short eop costs one block p1", 1'b1, 1, 7);
      accept();
      finish_burst(255);
      chk_req("R9 ceil charge p2", 1'b1, 2, 5);
      fifo_blocks = {5'd15, 5'd0, 5'd15, 5'd15};
      @(negedge clk);
      chk_req("R6 empty fifo skipped", 1'b1, 3, 3);
      fifo_blocks = ALL_FULL;

      // error handling, R10
      @(negedge clk);
      stat_err = 1'b1;
      @(negedge clk);
      stat_err = 1'b0;
      chk("R10 credits cleared", int'(req_valid), 0);
      for (int k = 0; k < 3; k++) send_stat(2'b00);
      chk("R10 ignored mid pass", int'(req_valid), 0);
      for (int k = 0; k < 5; k++) send_stat(2'b00);
      chk("R10 ignored through clean pass", int'(req_valid), 0);
      send_stat(2'b00);
      chk_req("R10 resume slot0 p0", 1'b1, 0, 8);
      send_stat(2'b01);
      chk_req("R2 slot1 p1 pointer at 2", 1'b1, 0, 8);
      fifo_blocks = {5'd15, 5'd15, 5'd15, 5'd0};
      @(negedge clk);
      chk_req("R4 p1 hungry load", 1'b1, 1, 4);

      // reset mid run, R1
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      fifo_blocks = ALL_FULL;
      @(negedge clk);
      chk("R1 reset clears credit", int'(req_valid), 0);
      summary();
   end

endmodule